// File: doc/BRIEF.md
# SPI Slave Pause Controller

This block sits in front of the bit engine of an SPI slave and implements the pause function driven by an active-low pause pin. It oversamples the serial clock, the active-low chip select and the pause pin with a fast system clock, and decides when the serial engine is paused. While paused, the controller stops the sample and shift strobes to the engine. It keeps the bit position where it is and withdraws the data output enable, so the serial output floats.

A pause starts or ends only while the synchronized serial clock is in its low phase. If the pause pin changes while the clock is high, the change waits until the clock is next low. A pause can begin only while chip select is active. If chip select is released during a pause, the pause is dropped and a one-cycle engine reset is issued. Because the bit position is frozen, shifting continues at the next bit after the pause ends. Data is sampled on rising serial clock edges and driven on falling edges, which suits clock modes 0 and 3.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `hold_active_o`, `so_oe_o`, `engine_reset_o` and the strobes are 0, and `bit_idx_o` is 0.
- R2: With chip select active and the synchronized clock low, a low pause pin sets `hold_active_o` within SYNC_STAGES+1 system clocks.
- R3: If the pause pin goes low while the serial clock is high, `hold_active_o` stays 0 until the clock is next low, and is then set.
- R4: A pause ends only while the serial clock is low. If the pause pin returns high while the clock is high, `hold_active_o` stays 1 until the clock is next low.
- R5: While chip select is inactive (high), a low pause pin never sets `hold_active_o`.
- R6: `so_oe_o` is 1 exactly when `so_req_i` is 1, chip select is active and no pause is in force. During a pause it is 0.
- R7: During a pause, serial clock edges produce no `sample_pulse_o` or `shift_pulse_o`, and `bit_idx_o` does not change.
- R8: Each rising serial clock edge outside a pause gives one `sample_pulse_o` and advances `bit_idx_o` by one, modulo WORD_BITS. `word_done_o` pulses on the edge that takes the index from WORD_BITS-1 back to 0. After a pause ends, counting resumes from the frozen index.
- R9: A rise of chip select during a pause gives a one-cycle `engine_reset_o`, clears `hold_active_o` and returns `bit_idx_o` to 0.
- R10: Chip select inactive clears `bit_idx_o` to 0 without a pause, and then `engine_reset_o` is not asserted.
- R11: Each falling serial clock edge outside a pause, with chip select active, gives one `shift_pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| cs_n_i | input | 1 | Active-low chip select pin, asynchronous |
| hold_n_i | input | 1 | Active-low pause pin, asynchronous |
| so_req_i | input | 1 | Serial engine requests to drive the data output |
| hold_active_o | output | 1 | Pause in force |
| so_oe_o | output | 1 | Output enable for the serial data pin |
| sample_pulse_o | output | 1 | One-cycle strobe: sample input bit (rising clock) |
| shift_pulse_o | output | 1 | One-cycle strobe: drive next output bit (falling clock) |
| bit_idx_o | output | $clog2(WORD_BITS) | Current bit position within the word |
| word_done_o | output | 1 | Strobe on the last bit of a word |
| engine_reset_o | output | 1 | One-cycle reset for the serial engine on release during pause |

## Verification
Two events can collide. One is a falling serial clock edge that also completes the pause entry condition. The other is a chip select release that arrives while a pause is in force. The first is provoked by lowering the pause pin while the clock is high and then lowering the clock. The bench expects the pause to be in force afterwards, and the bit index stays frozen across the clock cycles that follow. The second is provoked by releasing chip select during a pause. It is judged by a single reset strobe, a cleared pause flag and a zero bit index, all seen at the ports.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef enum logic {
    HS_RUN   = 1'b0,
    HS_PAUSE = 1'b1
  } hold_state_t;

  // Next bit position, wrapping at the word length.
  function automatic int unsigned bit_next(input int unsigned idx,
                                           input int unsigned word_bits);
    if (idx + 1 >= word_bits) return 0;
    return idx + 1;
  endfunction

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= RST_VAL;
    else        lvl_d <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_d;
  assign fall_o = ~lvl_i & lvl_d;

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_lvl_i,
  input  logic cs_n_lvl_i,
  input  logic hold_n_lvl_i,
  output logic hold_o,
  output logic abort_o
);

  hold_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cs_n_lvl_i) begin
      state_d = HS_RUN;
    end else if (!sck_lvl_i) begin
      // both entry and exit are only taken in the clock low phase
      state_d = hold_n_lvl_i ? HS_RUN : HS_PAUSE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_RUN;
    else        state_q <= state_d;
  end

  assign hold_o  = (state_q == HS_PAUSE);
  assign abort_o = hold_o & cs_n_lvl_i;

  a_r2_enter_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(!sck_lvl_i) && $past(!cs_n_lvl_i));

  a_r4_exit_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> $past(!sck_lvl_i) || $past(cs_n_lvl_i));

  a_r5_no_pause_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_lvl_i |=> !hold_o);

endmodule

// File: rtl/spi_hold_bitcnt.sv
module spi_hold_bitcnt
  import spi_hold_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8,
  localparam int unsigned IDX_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (adv_i)  idx_q <= IDX_W'(bit_next(int'(idx_q), WORD_BITS));
  end

  assign idx_o  = idx_q;
  assign last_o = (int'(idx_q) == WORD_BITS - 1);

  a_r8_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < WORD_BITS);

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WORD_BITS   = 8,
  localparam int unsigned IDX_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_i,
  input  logic             cs_n_i,
  input  logic             hold_n_i,
  input  logic             so_req_i,
  output logic             hold_active_o,
  output logic             so_oe_o,
  output logic             sample_pulse_o,
  output logic             shift_pulse_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             word_done_o,
  output logic             engine_reset_o
);

  localparam int unsigned NPIN = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b110; // {hold_n, cs_n, sck}

  logic [NPIN-1:0] pins_raw, pins_s;
  logic sck_s, cs_n_s, hold_n_s;
  logic sck_rise, sck_fall;
  logic hold_w, abort_w, last_w;
  logic run_w;

  assign pins_raw = {hold_n_i, cs_n_i, sck_i};

  spi_hold_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins_raw), .sync_o(pins_s)
  );

  assign sck_s    = pins_s[0];
  assign cs_n_s   = pins_s[1];
  assign hold_n_s = pins_s[2];

  spi_hold_edge #(.RST_VAL(PIN_IDLE[0])) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sck_s), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  spi_hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sck_lvl_i(sck_s), .cs_n_lvl_i(cs_n_s), .hold_n_lvl_i(hold_n_s),
    .hold_o(hold_w), .abort_o(abort_w)
  );

  assign run_w          = !cs_n_s && !hold_w;
  assign sample_pulse_o = sck_rise & run_w;
  assign shift_pulse_o  = sck_fall & run_w;

  spi_hold_bitcnt #(.WORD_BITS(WORD_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr_i(cs_n_s), .adv_i(sample_pulse_o),
    .idx_o(bit_idx_o), .last_o(last_w)
  );

  assign word_done_o    = sample_pulse_o & last_w;
  assign hold_active_o  = hold_w;
  assign engine_reset_o = abort_w;
  assign so_oe_o        = so_req_i & run_w;

  a_r6_output_floats_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active_o |-> !so_oe_o);

  a_r7_index_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active_o && !cs_n_s) |=> $stable(bit_idx_o));

  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    engine_reset_o |=> !hold_active_o && bit_idx_o == '0);

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pulse_o && shift_pulse_o));

endmodule

// File: tb/spi_hold_ctrl_tb.sv
module spi_hold_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic sck = 0, cs_n = 1, hold_n = 1, so_req = 0;
  logic hold_active, so_oe, sample_p, shift_p, word_done, eng_rst;
  logic [2:0] bit_idx;

  int checks = 0, errors = 0;
  int n_samp = 0, n_shift = 0, n_word = 0, n_rst = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .so_req_i(so_req), .hold_active_o(hold_active), .so_oe_o(so_oe),
    .sample_pulse_o(sample_p), .shift_pulse_o(shift_p), .bit_idx_o(bit_idx),
    .word_done_o(word_done), .engine_reset_o(eng_rst)
  );

  always @(negedge clk) begin
    if (sample_p)  n_samp++;
    if (shift_p)   n_shift++;
    if (word_done) n_word++;
    if (eng_rst)   n_rst++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_counts();
    n_samp = 0; n_shift = 0; n_word = 0; n_rst = 0;
  endtask

  task automatic sck_cycle();
    sck = 1; settle();
    sck = 0; settle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 hold", int'(hold_active), 0);
    chk("R1 oe", int'(so_oe), 0);
    chk("R1 idx", int'(bit_idx), 0);
    chk("R1 rst", int'(eng_rst), 0);
  endtask

  task automatic t_basic_shift();
    cs_n = 0; settle(); clr_counts();
    repeat (3) sck_cycle();
    chk("R8 idx after 3", int'(bit_idx), 3);
    chk("R8 samples", n_samp, 3);
    chk("R11 shifts", n_shift, 3);
    repeat (5) sck_cycle();
    chk("R8 wrap idx", int'(bit_idx), 0);
    chk("R8 word_done", n_word, 1);
  endtask

  task automatic t_hold_low_phase();
    so_req = 1; settle();
    chk("R6 oe running", int'(so_oe), 1);
    hold_n = 0; settle();
    chk("R2 enter", int'(hold_active), 1);
    chk("R6 oe paused", int'(so_oe), 0);
    clr_counts();
    repeat (2) sck_cycle();
    chk("R7 idx frozen", int'(bit_idx), 0);
    chk("R7 no samples", n_samp, 0);
    chk("R7 no shifts", n_shift, 0);
    hold_n = 1; settle();
    chk("R4 exit low", int'(hold_active), 0);
    chk("R6 oe back", int'(so_oe), 1);
    sck_cycle();
    chk("R8 resume", int'(bit_idx), 1);
  endtask

  task automatic t_hold_high_phase();
    sck = 1; settle();
    chk("R8 idx", int'(bit_idx), 2);
    hold_n = 0; settle();
    chk("R3 deferred", int'(hold_active), 0);
    sck = 0; settle();
    chk("R3 entered on low", int'(hold_active), 1);
    sck = 1; settle();
    chk("R7 frozen high", int'(bit_idx), 2);
    hold_n = 1; settle();
    chk("R4 exit deferred", int'(hold_active), 1);
    sck = 0; settle();
    chk("R4 exit on low", int'(hold_active), 0);
    sck_cycle();
    chk("R8 next bit", int'(bit_idx), 3);
  endtask

  task automatic t_deselect_gate();
    clr_counts();
    cs_n = 1; settle();
    chk("R10 idx cleared", int'(bit_idx), 0);
    chk("R10 no reset", n_rst, 0);
    hold_n = 0; settle();
    chk("R5 no pause", int'(hold_active), 0);
    sck_cycle();
    chk("R5 no strobes", n_samp + n_shift, 0);
    chk("R6 oe deselected", int'(so_oe), 0);
    hold_n = 1; settle();
  endtask

  task automatic t_abort();
    cs_n = 0; settle();
    repeat (2) sck_cycle();
    chk("R8 idx", int'(bit_idx), 2);
    hold_n = 0; settle();
    chk("R2 pause", int'(hold_active), 1);
    clr_counts();
    cs_n = 1; settle();
    chk("R9 hold cleared", int'(hold_active), 0);
    chk("R9 reset pulse", n_rst, 1);
    chk("R9 idx cleared", int'(bit_idx), 0);
    hold_n = 1; cs_n = 0; settle();
    chk("R9 after reselect", int'(hold_active), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    t_reset();
    t_basic_shift();
    t_hold_low_phase();
    t_hold_high_phase();
    t_deselect_gate();
    t_abort();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule